// File: doc/BRIEF.md
# Oscillator Source Switch Controller

This controller moves the system clock from the oscillator source now in use to a source that software asks for. Software places a 3-bit source code on `req_src` and pulses `sw_set`, which raises the switch-enable bit `sw_en`. The controller then checks the request. A request for the source already in use, for a direct move between the two PLL modes, or for an unused code is dropped at once by clearing `sw_en`. Any other request starts the switch sequence.

The switch sequence clears the lock and clock-fail status bits and enables the target oscillator. It waits for the crystal start-up timer when the target is a crystal, and for PLL lock when the target uses the PLL. It then lets the new clock settle for a fixed number of cycles. At changeover, `cur_src` and the registered clock select `clk_sel` take the new code and `sw_en` clears. The old oscillator's enable drops at the same time, unless a keep-alive condition holds for it.

A request that never completes, for example a PLL that never locks, leaves `sw_en` set and the lock bit clear until software pulses `sw_cancel` or reset is applied.

Top module: `osc_switch_ctrl`

## Requirements
- R1: Source codes are 0 fast RC, 1 fast RC with PLL, 2 primary, 3 primary with PLL, 4 secondary, 5 low-power RC. Oscillator enable and ready bits are [0] fast RC, [1] primary, [2] secondary, [3] low-power RC. After reset, `cur_src` and `clk_sel` are 0, `sw_en`, `lock` and `cf` are 0, `osc_en` is 4'b0001 and `pll_en` is 0.
- R2: A request equal to `cur_src` clears `sw_en` on the first edge after `sw_en` rises and leaves `cur_src` unchanged.
- R3: A request from code 1 to code 3 or from 3 to 1, or for code 6 or 7, is aborted in the same way as in R2.
- R4: On the first edge of a valid switch, `lock` and `cf` are cleared. This clear takes priority over a simultaneous `fail_det`.
- R5: While a switch is in progress, the target's oscillator enable is high. A crystal target (codes 2, 3, 4) does not advance until its `osc_ready` bit is 1.
- R6: A PLL target (codes 1, 3) does not advance until `pll_lock` is 1. Until then `sw_en` stays 1 and `lock` stays 0.
- R7: Once the target is ready, the changeover comes SETTLE_CYCLES (10) edges later. With ready and lock already high, `sw_en` clears 12 edges after the edge that set it for a non-PLL target, and 13 edges after it for a PLL target.
- R8: At changeover, on the same edge, `sw_en` clears and `cur_src` and `clk_sel` take the requested code.
- R9: After changeover, the old oscillator's enable is low. The exceptions are the low-power RC bit, which stays high while `wdt_fscm_en` is 1, and the secondary bit, which stays high while `sosc_keep` is 1. `pll_en` is high only when the current source or the in-progress target uses the PLL.
- R10: `sw_cancel` clears `sw_en`, ends any switch in progress and leaves `cur_src` unchanged.
- R11: `fail_det` sets the sticky `cf` bit. While idle, `lock` follows `pll_lock` when the current source uses the PLL and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_src | input | 3 | Requested source code |
| sw_set | input | 1 | Pulse that sets the switch-enable bit |
| sw_cancel | input | 1 | Pulse that withdraws the request |
| fail_det | input | 1 | Clock failure detected, sets cf |
| wdt_fscm_en | input | 1 | Watchdog or fail-safe monitor enabled |
| sosc_keep | input | 1 | Secondary oscillator keep-enabled bit |
| osc_ready | input | 4 | Per-oscillator ready (start-up timer expired) |
| pll_lock | input | 1 | PLL lock indication |
| cur_src | output | 3 | Current source status |
| clk_sel | output | 3 | Registered clock select |
| osc_en | output | 4 | Per-oscillator enable |
| pll_en | output | 1 | PLL enable |
| sw_en | output | 1 | Switch-enable bit, cleared by hardware |
| lock | output | 1 | Lock status bit |
| cf | output | 1 | Clock-fail status bit |

## Verification
Two events can land on one edge. The first is a clock-fail report arriving on the same edge that a valid switch starts. The bench raises `fail_det` in the cycle after `sw_set` and expects the switch-start clear to win, so `cf` reads 0. The second is the changeover edge, where the old oscillator's enable drops while a keep-alive condition may hold. The bench runs switches away from the low-power RC and secondary sources with their keep-alive inputs high and checks that those enables stay high after changeover. It then drops `sosc_keep` and checks that the secondary enable falls.

// File: rtl/osc_switch_ctrl.sv
module osc_switch_ctrl #(
  parameter int          SETTLE_CYCLES = 10,
  parameter logic [2:0]  RESET_SRC     = 3'd0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] req_src,
  input  logic       sw_set,
  input  logic       sw_cancel,
  input  logic       fail_det,
  input  logic       wdt_fscm_en,
  input  logic       sosc_keep,
  input  logic [3:0] osc_ready,
  input  logic       pll_lock,
  output logic [2:0] cur_src,
  output logic [2:0] clk_sel,
  output logic [3:0] osc_en,
  output logic       pll_en,
  output logic       sw_en,
  output logic       lock,
  output logic       cf
);

  localparam int CW = $clog2(SETTLE_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_RDY, S_LOCK, S_SETTLE} st_t;

  st_t           st;
  logic [2:0]    tgt;
  logic [CW-1:0] cnt;

  function automatic logic uses_pll(input logic [2:0] s);
    return (s == 3'd1) || (s == 3'd3);
  endfunction

  function automatic logic is_xtal(input logic [2:0] s);
    return (s == 3'd2) || (s == 3'd3) || (s == 3'd4);
  endfunction

  function automatic logic [3:0] osc_of(input logic [2:0] s);
    case (s)
      3'd0, 3'd1: return 4'b0001;
      3'd2, 3'd3: return 4'b0010;
      3'd4:       return 4'b0100;
      3'd5:       return 4'b1000;
      default:    return 4'b0000;
    endcase
  endfunction

  logic busy, bad_req, tgt_ready;

  assign busy      = (st != S_IDLE);
  assign bad_req   = (req_src > 3'd5) || (req_src == cur_src) ||
                     (uses_pll(req_src) && uses_pll(cur_src));
  assign tgt_ready = !is_xtal(tgt) || |(osc_ready & osc_of(tgt));
  assign osc_en    = osc_of(cur_src) | (busy ? osc_of(tgt) : 4'b0000) |
                     {wdt_fscm_en, sosc_keep, 2'b00};
  assign pll_en    = uses_pll(cur_src) | (busy & uses_pll(tgt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tgt     <= RESET_SRC;
      cnt     <= '0;
      cur_src <= RESET_SRC;
      clk_sel <= RESET_SRC;
      sw_en   <= 1'b0;
      lock    <= 1'b0;
      cf      <= 1'b0;
    end else begin
      if (fail_det) cf <= 1'b1;
      if (sw_cancel) begin
        sw_en <= 1'b0;
        st    <= S_IDLE;
        if (!busy) lock <= pll_lock && uses_pll(cur_src);
      end else begin
        case (st)
          S_IDLE: begin
            lock <= pll_lock && uses_pll(cur_src);
            if (!sw_en) begin
              if (sw_set) sw_en <= 1'b1;
            end else if (bad_req) begin
              sw_en <= 1'b0;
            end else begin
              tgt  <= req_src;
              lock <= 1'b0;
              cf   <= 1'b0;
              st   <= S_RDY;
            end
          end
          S_RDY: begin
            if (tgt_ready) begin
              cnt <= '0;
              st  <= uses_pll(tgt) ? S_LOCK : S_SETTLE;
            end
          end
          S_LOCK: begin
            if (pll_lock) begin
              lock <= 1'b1;
              cnt  <= '0;
              st   <= S_SETTLE;
            end
          end
          S_SETTLE: begin
            if (cnt == CW'(SETTLE_CYCLES - 1)) begin
              cur_src <= tgt;
              clk_sel <= tgt;
              sw_en   <= 1'b0;
              st      <= S_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

module osc_switch_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] req_src,
  input logic       sw_cancel,
  input logic       pll_lock,
  input logic [2:0] cur_src,
  input logic [2:0] clk_sel,
  input logic [3:0] osc_en,
  input logic       sw_en,
  input logic       lock,
  input logic       cf,
  input logic [1:0] st,
  input logic [2:0] tgt
);

  logic idle_req;
  assign idle_req = (st == 2'd0) && sw_en && !sw_cancel;

  assert_redundant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && req_src == cur_src) |=> (!sw_en && $stable(cur_src)));

  assert_pll_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && ((req_src == 3'd1 && cur_src == 3'd3) || (req_src == 3'd3 && cur_src == 3'd1)))
      |=> (!sw_en && $stable(cur_src)));

  assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && req_src != cur_src) |=> (!sw_en || (!lock && !cf)));

  assert_target_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd0) |-> |osc_en);

  assert_wait_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && !pll_lock && !sw_cancel) |=> (st == 2'd2 && sw_en && !lock));

  assert_changeover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_src != $past(cur_src)) |-> ($past(sw_en) && !sw_en && clk_sel == cur_src));

  assert_cancel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_cancel |=> (!sw_en && $stable(cur_src)));

  assert_tgt_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd0) |-> (tgt <= 3'd5));

endmodule

bind osc_switch_ctrl osc_switch_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_src(req_src), .sw_cancel(sw_cancel),
  .pll_lock(pll_lock), .cur_src(cur_src), .clk_sel(clk_sel), .osc_en(osc_en),
  .sw_en(sw_en), .lock(lock), .cf(cf), .st(st), .tgt(tgt)
);

// File: tb/tb_osc_switch_ctrl.sv
module tb_osc_switch_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] req_src = 3'd0;
  logic       sw_set = 1'b0, sw_cancel = 1'b0, fail_det = 1'b0;
  logic       wdt_fscm_en = 1'b0, sosc_keep = 1'b0;
  logic [3:0] osc_ready = 4'hF;
  logic       pll_lock = 1'b1;
  logic [2:0] cur_src, clk_sel;
  logic [3:0] osc_en;
  logic       pll_en, sw_en, lock, cf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  osc_switch_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_src(req_src), .sw_set(sw_set),
    .sw_cancel(sw_cancel), .fail_det(fail_det), .wdt_fscm_en(wdt_fscm_en),
    .sosc_keep(sosc_keep), .osc_ready(osc_ready), .pll_lock(pll_lock),
    .cur_src(cur_src), .clk_sel(clk_sel), .osc_en(osc_en), .pll_en(pll_en),
    .sw_en(sw_en), .lock(lock), .cf(cf)
  );

  // {req, expected cur_src, expected edges until sw_en clears}
  localparam logic [10:0] VEC [11] = '{
    {3'd2, 3'd2, 5'd12},
    {3'd2, 3'd2, 5'd1},
    {3'd3, 3'd3, 5'd13},
    {3'd1, 3'd3, 5'd1},
    {3'd0, 3'd0, 5'd12},
    {3'd1, 3'd1, 5'd13},
    {3'd3, 3'd1, 5'd1},
    {3'd4, 3'd4, 5'd12},
    {3'd5, 3'd5, 5'd12},
    {3'd0, 3'd0, 5'd12},
    {3'd7, 3'd0, 5'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic request(input logic [2:0] s);
    @(negedge clk);
    req_src = s;
    sw_set  = 1'b1;
    @(negedge clk);
    sw_set  = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      n++;
      if (!sw_en) break;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 cur_src", cur_src, 0);
    chk("R1 clk_sel", clk_sel, 0);
    chk("R1 flags", {sw_en, lock, cf, pll_en}, 0);
    chk("R1 osc_en", osc_en, 4'b0001);
    rst_n = 1'b1;

    for (int v = 0; v < 11; v++) begin
      request(VEC[v][10:8]);
      wait_done(n);
      chk("R2/R3/R7 latency", n, VEC[v][4:0]);
      chk("R8 cur_src", cur_src, VEC[v][7:5]);
      chk("R8 clk_sel", clk_sel, VEC[v][7:5]);
    end
    chk("R9 old off after 5->0", osc_en, 4'b0001);

    request(3'd1);
    wait_done(n);
    @(negedge clk);
    chk("R11 lock follows pll", lock, 1);
    fail_det = 1'b1;
    @(negedge clk);
    fail_det = 1'b0;
    chk("R11 cf sticky", cf, 1);
    osc_ready = 4'b1101;
    request(3'd2);
    fail_det = 1'b1;
    @(negedge clk);
    fail_det = 1'b0;
    chk("R4 lock cleared", lock, 0);
    chk("R4 cf cleared over fail_det", cf, 0);
    repeat (40) @(negedge clk);
    chk("R5 crystal wait holds sw_en", sw_en, 1);
    chk("R5 cur unchanged", cur_src, 1);
    chk("R5 target enabled", osc_en[1], 1);
    osc_ready = 4'hF;
    wait_done(n);
    chk("R7 settle after ready", n, 11);
    chk("R8 now primary", cur_src, 2);
    chk("R9 fast RC off", osc_en, 4'b0010);
    chk("R9 pll off", pll_en, 0);

    pll_lock = 1'b0;
    request(3'd3);
    repeat (50) @(negedge clk);
    chk("R6 sw_en held", sw_en, 1);
    chk("R6 lock low", lock, 0);
    chk("R6 cur unchanged", cur_src, 2);
    chk("R9 pll on for target", pll_en, 1);
    @(negedge clk);
    sw_cancel = 1'b1;
    @(negedge clk);
    sw_cancel = 1'b0;
    chk("R10 sw_en cleared", sw_en, 0);
    chk("R10 cur kept", cur_src, 2);
    chk("R10 pll off", pll_en, 0);

    pll_lock = 1'b1;
    request(3'd3);
    wait_done(n);
    chk("R7 pll latency", n, 13);
    chk("R8 primary pll", cur_src, 3);

    wdt_fscm_en = 1'b1;
    sosc_keep   = 1'b1;
    request(3'd5);
    wait_done(n);
    request(3'd4);
    wait_done(n);
    request(3'd0);
    wait_done(n);
    chk("R8 back to fast RC", cur_src, 0);
    chk("R9 keep-alive", osc_en, 4'b1101);
    @(negedge clk);
    sosc_keep = 1'b0;
    #1;
    chk("R9 secondary released", osc_en, 4'b1001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule